// File: doc/BRIEF.md
# Iterative Waveform Update Sequencer

This block paces the replay of a stored sample list toward an output converter. Software loads the interval between updates, the number of samples in one waveform, the number of times the waveform repeats and two optional waits. It then arms the block with a start pulse. A rising edge on the trigger input launches a generation. The block can first wait a programmable number of cycles. It then emits one update strobe per interval, with the buffer read index that goes with each strobe. After the last sample of a waveform the index returns to zero. An optional gap is inserted before the waveform plays again. The waveform repeats a set number of times, or without end.

The update period in seconds is the interval count divided by the timebase frequency. The system integrator chooses the interval so that updates stay at or below one million per second. The sample list holds up to `DEPTH` entries. This is 2048 by default, which suits one active channel. A two-channel system would set it to 1024. A busy output is high for the whole of a generation. While it is high, further trigger edges have no effect. When re-trigger is enabled, a finished generation leaves the block armed for the next trigger. A stop pulse ends a generation at once.

Top module: `wfseq_top`

## Requirements
- R1: After reset `busy`, `upd_strobe` and `rd_index` are 0, and trigger edges are ignored until `sw_start` has armed the block.
- R2: Within a waveform, consecutive strobes are exactly `interval` cycles apart, and an interval of 0 behaves as 1.
- R3: With `delay_mode`=0, the first strobe is high in the cycle right after the clock edge that sees the trigger rise. Within each waveform the strobes carry `rd_index` 0, 1, ... up to `updates`-1.
- R4: With `delay_mode`=1, the first strobe comes `delay1` cycles later than it would with `delay_mode`=0. A `delay1` of 0 gives the same timing as `delay_mode`=0.
- R5: A generation holds `iters` waveforms (0 behaves as 1), and `rd_index` returns to 0 at the start of each waveform.
- R6: The first strobe of a repeated waveform comes `interval`+`delay2` cycles after the last strobe of the previous one, so a `delay2` of 0 gives back-to-back waveforms.
- R7: With `infinite_en`=1 the waveform repeats, with `busy` held high, until `sw_stop` is pulsed.
- R8: `busy` rises together with the first cycle after the trigger edge. It falls in the cycle after the last strobe of the last waveform.
- R9: Only a rising edge of `trig_in` counts as a trigger. Trigger edges that arrive while `busy` is high change neither the strobe timing nor the strobe count.
- R10: When a generation ends with `retrig_en`=1, the next trigger edge starts a new generation. With `retrig_en`=0 the block ignores triggers until `sw_start` arms it again.
- R11: A `sw_stop` pulse while `busy` is high drops `busy` and `upd_strobe` and sets `rd_index` to 0 in the next cycle. The block is then armed again.
- R12: An `updates` value above `DEPTH` plays `DEPTH` samples, and a value of 0 plays one sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_start | input | 1 | Arms the block to wait for a trigger |
| sw_stop | input | 1 | Aborts a running generation and re-arms |
| trig_in | input | 1 | Trigger; its rising edge starts a generation |
| delay_mode | input | 1 | 1 inserts `delay1` before the first update |
| retrig_en | input | 1 | 1 re-arms the block after a generation ends |
| infinite_en | input | 1 | 1 repeats the waveform until stopped |
| interval | input | TMR_W | Cycles between updates |
| delay1 | input | TMR_W | Wait from trigger to first update, in cycles |
| delay2 | input | TMR_W | Extra gap between waveforms, in cycles |
| updates | input | IDX_W+1 | Samples per waveform |
| iters | input | ITER_W | Waveforms per generation |
| upd_strobe | output | 1 | One-cycle update pulse |
| rd_index | output | IDX_W | Buffer index to read with the current strobe |
| busy | output | 1 | A generation is in progress |

## Verification
The bench runs single-waveform generations with immediate start under several intervals, including 0 and 1. These show the spacing rule and the index ramp. Runs that change only `delay1` or only `delay2` show that each wait moves only its own boundary: the trigger-to-first-update boundary or the waveform-to-waveform boundary. A multi-iteration run with no gap, an infinite run and an oversized sample count test the wrap and clamp rules. Trigger pulses placed before arming, during a generation and after it finishes, with re-trigger on and off, show which triggers the block accepts. A stop pulse in the middle of an infinite run tests the abort.

// File: rtl/wfseq_pkg.sv
package wfseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_DLY1  = 3'd2,
        ST_RUN   = 3'd3,
        ST_DLY2  = 3'd4
    } seq_state_e;
endpackage

// File: rtl/wfseq_edge.sv
module wfseq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb prev_d = sig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = sig & ~prev_q;
endmodule

// File: rtl/wfseq_timer.sv
module wfseq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/wfseq_top.sv
module wfseq_top
    import wfseq_pkg::*;
#(
    parameter  int DEPTH  = 2048,
    parameter  int TMR_W  = 16,
    parameter  int ITER_W = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int UPD_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_start,
    input  logic              sw_stop,
    input  logic              trig_in,
    input  logic              delay_mode,
    input  logic              retrig_en,
    input  logic              infinite_en,
    input  logic [TMR_W-1:0]  interval,
    input  logic [TMR_W-1:0]  delay1,
    input  logic [TMR_W-1:0]  delay2,
    input  logic [UPD_W-1:0]  updates,
    input  logic [ITER_W-1:0] iters,
    output logic              upd_strobe,
    output logic [IDX_W-1:0]  rd_index,
    output logic              busy
);
    localparam logic [UPD_W-1:0] DEPTH_V = UPD_W'(DEPTH);

    typedef struct packed {
        seq_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [ITER_W-1:0] iter;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             trig_evt;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;

    logic [TMR_W-1:0]  int_eff;
    logic [UPD_W-1:0]  upd_eff;
    logic [ITER_W-1:0] iter_eff;
    logic              last_upd;
    logic              last_iter;
    logic              active;

    wfseq_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (trig_in),
        .rise (trig_evt)
    );

    wfseq_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    always_comb begin
        int_eff  = (interval == '0) ? TMR_W'(1) : interval;
        iter_eff = (iters == '0) ? ITER_W'(1) : iters;
        if (updates == '0)          upd_eff = UPD_W'(1);
        else if (updates > DEPTH_V) upd_eff = DEPTH_V;
        else                        upd_eff = updates;
        last_upd  = ({1'b0, seq_q.idx} == (upd_eff - UPD_W'(1)));
        last_iter = !infinite_en && (seq_q.iter == (iter_eff - ITER_W'(1)));
        active    = (seq_q.st == ST_DLY1) || (seq_q.st == ST_RUN) ||
                    (seq_q.st == ST_DLY2);
    end

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (sw_start) seq_d.st = ST_ARMED;
            end
            ST_ARMED: begin
                if (trig_evt) begin
                    seq_d.idx  = '0;
                    seq_d.iter = '0;
                    tmr_load   = 1'b1;
                    if (delay_mode && (delay1 != '0)) begin
                        seq_d.st = ST_DLY1;
                        tmr_val  = delay1 - TMR_W'(1);
                    end else begin
                        seq_d.st = ST_RUN;
                    end
                end
            end
            ST_DLY1: begin
                if (tmr_zero) begin
                    seq_d.st = ST_RUN;
                    tmr_load = 1'b1;
                end
            end
            ST_RUN: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = int_eff - TMR_W'(1);
                    if (last_upd) begin
                        seq_d.idx = '0;
                        if (last_iter) begin
                            seq_d.st = retrig_en ? ST_ARMED : ST_IDLE;
                        end else begin
                            seq_d.iter = seq_q.iter + ITER_W'(1);
                            if (delay2 != '0) begin
                                seq_d.st = ST_DLY2;
                                tmr_val  = delay2 - TMR_W'(1);
                            end
                        end
                    end else begin
                        seq_d.idx = seq_q.idx + IDX_W'(1);
                    end
                end
            end
            ST_DLY2: begin
                if (tmr_zero) begin
                    seq_d.st = ST_RUN;
                    tmr_load = 1'b1;
                    tmr_val  = int_eff - TMR_W'(1);
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase

        if (sw_stop && active) begin
            seq_d.st   = ST_ARMED;
            seq_d.idx  = '0;
            seq_d.iter = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.idx  <= '0;
            seq_q.iter <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign upd_strobe = (seq_q.st == ST_RUN) && tmr_zero;
    assign rd_index   = seq_q.idx;
    assign busy       = active;
endmodule

// File: rtl/wfseq_checks.sv
module wfseq_checks #(
    parameter int TMR_W = 16,
    parameter int IDX_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_stop,
    input logic             trig_in,
    input logic [TMR_W-1:0] interval,
    input logic             upd_strobe,
    input logic [IDX_W-1:0] rd_index,
    input logic             busy
);
    // R8: a strobe only appears during a generation
    assert_strobe_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |-> busy);

    // R2: intervals above one leave a quiet cycle after each strobe
    assert_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_strobe && (interval > TMR_W'(1))) |=> !upd_strobe);

    // R3/R5: back-to-back strobes step the index by one or wrap to zero
    assert_index_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_strobe && !sw_stop) |=>
            (!upd_strobe || rd_index == $past(rd_index) + IDX_W'(1) || rd_index == '0));

    // R11: a stop ends the generation in the next cycle
    assert_stop_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stop && busy) |=> (!busy && !upd_strobe && rd_index == '0));

    // R9: a generation only begins on a sampled trigger
    assert_busy_needs_trig_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(trig_in));
endmodule

bind wfseq_top wfseq_checks #(.TMR_W(TMR_W), .IDX_W(IDX_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_stop   (sw_stop),
    .trig_in   (trig_in),
    .interval  (interval),
    .upd_strobe(upd_strobe),
    .rd_index  (rd_index),
    .busy      (busy)
);

// File: tb/tb_wfseq_top.sv
module tb_wfseq_top;
    localparam int DEPTH  = 2048;
    localparam int TMR_W  = 16;
    localparam int ITER_W = 16;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int UPD_W  = IDX_W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_start = 1'b0, sw_stop = 1'b0, trig_in = 1'b0;
    logic delay_mode = 1'b0, retrig_en = 1'b1, infinite_en = 1'b0;
    logic [TMR_W-1:0]  interval = '0, delay1 = '0, delay2 = '0;
    logic [UPD_W-1:0]  updates = '0;
    logic [ITER_W-1:0] iters = '0;
    logic              upd_strobe, busy;
    logic [IDX_W-1:0]  rd_index;

    int n_tests = 0;
    int n_fail  = 0;
    int edges   = 0;

    always #2 clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    wfseq_top #(.DEPTH(DEPTH), .TMR_W(TMR_W), .ITER_W(ITER_W)) dut (
        .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .sw_stop(sw_stop),
        .trig_in(trig_in), .delay_mode(delay_mode), .retrig_en(retrig_en),
        .infinite_en(infinite_en), .interval(interval), .delay1(delay1),
        .delay2(delay2), .updates(updates), .iters(iters),
        .upd_strobe(upd_strobe), .rd_index(rd_index), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_trig(output int base);
        @(negedge clk); trig_in = 1'b1; base = edges;
        @(negedge clk); trig_in = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
    endtask

    // Trigger a finite generation and compare every strobe with the timing model.
    task automatic run_wave(input string tag, input int iv, input int up, input int it,
                            input int d1, input int d2, input bit dm,
                            input int extra_trig_at);
        int base, j, ie, ue, ne, d1e, total, exp_off, last_off, off, bad_t, bad_i;
        int got_t, exp_t, got_i, exp_i;
        bit first_busy;
        ie  = (iv == 0) ? 1 : iv;
        ue  = (up == 0) ? 1 : ((up > DEPTH) ? DEPTH : up);
        ne  = (it == 0) ? 1 : it;
        d1e = dm ? d1 : 0;
        total = ue * ne;
        interval = TMR_W'(iv); updates = UPD_W'(up); iters = ITER_W'(it);
        delay1 = TMR_W'(d1); delay2 = TMR_W'(d2); delay_mode = dm; infinite_en = 1'b0;
        pulse_trig(base);
        j = 0; bad_t = 0; bad_i = 0; got_t = 0; exp_t = 0; got_i = 0; exp_i = 0;
        last_off = 0;
        off = edges - base;
        first_busy = busy;
        while ((busy || off < 2) && off < 20000) begin
            if (extra_trig_at != 0 && off == extra_trig_at) trig_in = 1'b1;
            else trig_in = 1'b0;
            if (upd_strobe) begin
                exp_off = 1 + d1e + j * ie + (j / ue) * d2;
                if (off != exp_off && bad_t == 0) begin bad_t = 1; got_t = off; exp_t = exp_off; end
                if (int'(rd_index) != (j % ue) && bad_i == 0) begin
                    bad_i = 1; got_i = int'(rd_index); exp_i = j % ue;
                end
                last_off = off;
                j++;
            end
            @(negedge clk);
            off = edges - base;
        end
        trig_in = 1'b0;
        check(first_busy, {tag, " busy after trigger"}, first_busy, 1);
        check(bad_t == 0, {tag, " strobe timing"}, got_t, exp_t);
        check(bad_i == 0, {tag, " read index"}, got_i, exp_i);
        check(j == total, {tag, " strobe count"}, j, total);
        check(off == last_off + 1, {tag, " busy fall"}, off, last_off + 1);
    endtask

    task automatic t_reset();
        int base;
        check(!busy && !upd_strobe && rd_index == '0, "R1 reset outputs",
              {busy, upd_strobe, rd_index}, 0);
        pulse_trig(base);
        repeat (3) @(negedge clk);
        check(!busy && !upd_strobe, "R1 trigger before arm ignored", busy, 0);
        pulse_start();
    endtask

    task automatic t_retrig_on();
        int base;
        retrig_en = 1'b1;
        run_wave("R9 retrigger while busy", 3, 2, 1, 0, 0, 1'b0, 2);
        pulse_trig(base);
        check(busy, "R10 retrigger starts new run", busy, 1);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_retrig_off();
        int base;
        retrig_en = 1'b0;
        run_wave("R10 single shot", 1, 2, 1, 0, 0, 1'b0, 0);
        pulse_trig(base);
        repeat (2) @(negedge clk);
        check(!busy, "R10 trigger ignored without rearm", busy, 0);
        pulse_start();
        retrig_en = 1'b1;
        pulse_trig(base);
        check(busy, "R10 rearmed by start", busy, 1);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_held_trigger();
        int base;
        interval = 1; updates = 2; iters = 1; delay_mode = 1'b0; infinite_en = 1'b0;
        @(negedge clk); trig_in = 1'b1; base = edges;
        repeat (6) @(negedge clk);
        check(!busy, "R9 held trigger fires once", busy, 0);
        trig_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_infinite_stop();
        int base, bad, j, got, exp;
        interval = 2; updates = 3; iters = 1; delay2 = 0; delay_mode = 1'b0;
        infinite_en = 1'b1;
        pulse_trig(base);
        bad = 0; j = 0; got = 0; exp = 0;
        for (int k = 0; k < 40; k++) begin
            if (!busy && bad == 0) begin bad = 1; got = 0; exp = 1; end
            if (upd_strobe) begin
                if (int'(rd_index) != (j % 3) && bad == 0) begin
                    bad = 1; got = int'(rd_index); exp = j % 3;
                end
                j++;
            end
            @(negedge clk);
        end
        check(bad == 0, "R7 infinite repetition", got, exp);
        check(j == 20, "R7 infinite strobe count", j, 20);
        sw_stop = 1'b1;
        @(negedge clk); sw_stop = 1'b0;
        check(!busy && !upd_strobe && rd_index == '0, "R11 stop aborts",
              {busy, upd_strobe, rd_index}, 0);
        repeat (4) @(negedge clk);
        check(!busy && !upd_strobe, "R11 stays stopped", busy, 0);
        infinite_en = 1'b0;
        pulse_trig(base);
        check(busy, "R11 rearmed after stop", busy, 1);
        repeat (12) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_wave("R3 post interval 4", 4, 5, 1, 0, 0, 1'b0, 0);
        run_wave("R2 interval 0", 0, 4, 1, 0, 0, 1'b0, 0);
        run_wave("R2 interval 1", 1, 6, 1, 0, 0, 1'b0, 0);
        run_wave("R4 delay1 7", 3, 4, 1, 7, 0, 1'b1, 0);
        run_wave("R4 delay1 zero", 3, 4, 1, 0, 0, 1'b1, 0);
        run_wave("R4 delay ignored in post", 2, 3, 1, 9, 0, 1'b0, 0);
        run_wave("R5 iterations back to back", 2, 4, 3, 0, 0, 1'b0, 0);
        run_wave("R6 delay2 gap", 3, 4, 3, 2, 5, 1'b1, 0);
        run_wave("R5 iters zero", 2, 3, 0, 0, 0, 1'b0, 0);
        run_wave("R12 updates zero", 2, 0, 2, 0, 1, 1'b0, 0);
        run_wave("R12 updates clamped", 1, 4095, 1, 0, 0, 1'b0, 0);
        t_retrig_on();
        t_retrig_off();
        t_held_trigger();
        t_infinite_stop();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule